// File: doc/BRIEF.md
# Depth-Cascaded FIFO Chain

This block forms one deep single-clock FIFO from a chain of smaller FIFO stages placed end to end. Every stage but the final one presents its oldest word on its output before any read is issued. Between each pair of neighbouring stages, a one-gate strobe moves a word forward in any cycle where the upstream stage is not empty and the downstream stage is not full. That strobe is both the upstream read and the downstream write.

Writers see only the first stage: its full and almost-full flags are the external ones. Readers see only the last stage: its empty and almost-empty flags are the external ones, and it is a registered-output FIFO whose data port updates on the clock edge that accepts a read. Total capacity is the number of stages times the per-stage depth. A word written into an empty chain needs one cycle per stage to reach the read port.

Top module: `fifo_chain`

## Requirements
- R1: The number of stages `STAGES` is at least 2. With 2 stages, the first stage feeds the last directly.
- R2: A word written into an empty chain on clock edge k clears `empty` after edge k+STAGES-1. Each link strobe is followed one cycle later by a non-empty downstream stage.
- R3: With continuous writes and no reads, `full` asserts once STAGES*STAGE_DEPTH words have been accepted. A write while `full` is high stores nothing.
- R4: A read while `empty` is high is ignored. `rd_data` holds, `empty` stays high, and the next word written is the next word read.
- R5: `almost_full` is high exactly when the first stage holds at least STAGE_DEPTH-AF_GAP words. `full` implies `almost_full` in every stage.
- R6: `almost_empty` is high exactly when the last stage holds at most AE_GAP words. `empty` implies `almost_empty` in every stage.
- R7: `rd_data` takes the head word on the edge that accepts a read (`rd_en` high while `empty` is low). Otherwise it holds its value.
- R8: After reset, `empty` and `almost_empty` are 1 and `full` and `almost_full` are 0. `rd_data` is 0.
- R9: Words leave the chain in exactly the order they were accepted, including under mixed bursts with reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | First stage is full |
| almost_full | output | 1 | First stage at or above its high-water level |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word of the last stage |
| empty | output | 1 | Last stage is empty |
| almost_empty | output | 1 | Last stage at or below its low-water level |

## Verification
Every cycle, the assertions check four things:
- No stage's occupancy exceeds its depth, and no stage is full and empty at once.
- A blocked write or read leaves the pointers untouched, and the last stage's output holds when no read is accepted.
- Each link strobe lands a word downstream.
- Full and empty each imply their "almost" companion.

Only the bench's scenarios can show end-to-end behaviour. These cover:
- ordering across the whole chain;
- the exact STAGES-1 cycle fall-through latency;
- total capacity;
- the positions of the almost flags for a given fill level after the chain settles.

// File: rtl/fq_pkg.sv
package fq_pkg;

    typedef enum logic {
        MODE_STANDARD = 1'b0,
        MODE_FWFT     = 1'b1
    } fq_mode_e;

    function automatic int fq_next(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/fq_link.sv
module fq_link (
    input  logic up_empty,
    input  logic dn_full,
    output logic xfer
);
    // One strobe drives the upstream read and the downstream write.
    assign xfer = ~(up_empty | dn_full);
endmodule

// File: rtl/fq_stage.sv
module fq_stage
    import fq_pkg::*;
#(
    parameter int       W      = 4,
    parameter int       DEPTH  = 512,
    parameter int       AF_GAP = 16,
    parameter int       AE_GAP = 16,
    parameter fq_mode_e MODE   = MODE_STANDARD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty,
    output logic         almost_full,
    output logic         almost_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] AF_LEVEL = CW'(DEPTH - AF_GAP);
    localparam logic [CW-1:0] AE_LEVEL = CW'(AE_GAP);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          full;
        logic          empty;
        logic          afull;
        logic          aempty;
        logic [W-1:0]  dout;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    always_comb begin
        wr_ok = wr_en & ~s_q.full;
        rd_ok = rd_en & ~s_q.empty;
        s_d   = s_q;
        if (wr_ok) s_d.wptr = AW'(fq_next(int'(s_q.wptr), DEPTH));
        if (rd_ok) begin
            s_d.rptr = AW'(fq_next(int'(s_q.rptr), DEPTH));
            s_d.dout = mem[s_q.rptr];
        end
        unique case ({wr_ok, rd_ok})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
        s_d.full   = (s_d.count == FULL_CNT);
        s_d.empty  = (s_d.count == '0);
        s_d.afull  = (s_d.count >= AF_LEVEL);
        s_d.aempty = (s_d.count <= AE_LEVEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.empty  <= 1'b1;
            s_q.aempty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[s_q.wptr] <= wr_data;
    end

    generate
        if (MODE == MODE_FWFT) begin : g_fwft
            assign rd_data = mem[s_q.rptr];
        end else begin : g_std
            assign rd_data = s_q.dout;
            // R7: registered output moves only on an accepted read
            p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_en && !empty) |=> $stable(rd_data));
        end
    endgenerate

    assign full         = s_q.full;
    assign empty        = s_q.empty;
    assign almost_full  = s_q.afull;
    assign almost_empty = s_q.aempty;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= FULL_CNT);
    p_blocked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(s_q.wptr));
    p_blocked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(s_q.rptr));
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import fq_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter int STAGE_DEPTH = 512,
    parameter int STAGES      = 2,
    parameter int AF_GAP      = 16,
    parameter int AE_GAP      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty
);
    localparam int LAST  = STAGES - 1;
    localparam int LINKS = STAGES - 1;

    logic [DATA_W-1:0] s_din  [STAGES];
    logic [DATA_W-1:0] s_dout [STAGES];
    logic [STAGES-1:0] s_we, s_re, s_full, s_empty, s_af, s_ae;
    logic [LINKS-1:0]  xfer;

    // R1: a chain needs a head stage and a tail stage
    initial begin
        a_min_stages_r1: assert (STAGES >= 2)
            else $error("fifo_chain: STAGES must be at least 2");
    end

    assign s_we[0]    = wr_en;
    assign s_din[0]   = wr_data;
    assign s_re[LAST] = rd_en;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            localparam fq_mode_e SMODE = (i < LAST) ? MODE_FWFT : MODE_STANDARD;
            fq_stage #(
                .W(DATA_W), .DEPTH(STAGE_DEPTH),
                .AF_GAP(AF_GAP), .AE_GAP(AE_GAP), .MODE(SMODE)
            ) u_stage (
                .clk(clk), .rst_n(rst_n),
                .wr_en(s_we[i]), .wr_data(s_din[i]),
                .rd_en(s_re[i]), .rd_data(s_dout[i]),
                .full(s_full[i]), .empty(s_empty[i]),
                .almost_full(s_af[i]), .almost_empty(s_ae[i])
            );
            p_full_af_r5: assert property (@(posedge clk) disable iff (!rst_n)
                s_full[i] |-> s_af[i]);
            p_empty_ae_r6: assert property (@(posedge clk) disable iff (!rst_n)
                s_empty[i] |-> s_ae[i]);
        end

        for (genvar j = 0; j < LINKS; j++) begin : g_link
            fq_link u_link (
                .up_empty(s_empty[j]),
                .dn_full(s_full[j+1]),
                .xfer(xfer[j])
            );
            assign s_re[j]    = xfer[j];
            assign s_we[j+1]  = xfer[j];
            assign s_din[j+1] = s_dout[j];
            // R2: each strobe lands a word in the next stage
            p_link_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
                xfer[j] |=> !s_empty[j+1]);
        end
    endgenerate

    assign full         = s_full[0];
    assign almost_full  = s_af[0];
    assign empty        = s_empty[LAST];
    assign almost_empty = s_ae[LAST];
    assign rd_data      = s_dout[LAST];
endmodule

// File: tb/sim_fifo_chain.sv
`timescale 1ns/1ps
module sim_fifo_chain;
    localparam int W = 8, D = 4, N = 3, AFG = 1, AEG = 1;
    localparam int CAP = N * D;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic full, almost_full, empty, almost_empty;

    int checks = 0, fails = 0;

    fifo_chain #(.DATA_W(W), .STAGE_DEPTH(D), .STAGES(N), .AF_GAP(AFG), .AE_GAP(AEG)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty));

    always #2 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_run(input int n, input int base);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = W'(base + j);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R9 ordering: read n words, expect base, base+1, ...
    task automatic drain(input int n, input int base);
        int got = 0, idx = 0, guard = 0;
        bit pend = 1'b0;
        while ((idx < n || pend) && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (pend) begin
                chk(rd_data == W'(base + got), "R9 order", int'(rd_data), (base + got) & 8'hFF);
                got++; pend = 1'b0;
            end
            if (idx < n && !empty) begin
                rd_en = 1'b1; pend = 1'b1; idx++;
            end else begin
                rd_en = 1'b0;
            end
        end
        rd_en = 1'b0;
        chk(got == n, "R9 drain count", got, n);
    endtask

    // fill level k -> expected {empty, almost_empty, almost_full, full} after settling
    typedef struct packed { int k; bit e; bit ae; bit af; bit f; } vec_t;
    localparam vec_t VECS [7] = '{
        '{0,  1'b1, 1'b1, 1'b0, 1'b0},
        '{1,  1'b0, 1'b1, 1'b0, 1'b0},
        '{2,  1'b0, 1'b0, 1'b0, 1'b0},
        '{4,  1'b0, 1'b0, 1'b0, 1'b0},
        '{10, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11, 1'b0, 1'b0, 1'b1, 1'b0},
        '{12, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic [W-1:0] refq [4096];

    initial begin
        // R8 reset state
        do_reset();
        @(negedge clk);
        chk({empty, almost_empty, almost_full, full} == 4'b1100, "R8 reset flags",
            int'({empty, almost_empty, almost_full, full}), 4'b1100);
        chk(rd_data == '0, "R8 reset data", int'(rd_data), 0);

        // R5 R6 R3: flag positions per fill level, then ordered drain
        foreach (VECS[v]) begin
            do_reset();
            if (VECS[v].k > 0) write_run(VECS[v].k, 16 + v * 16);
            repeat (40) @(negedge clk);
            chk({empty, almost_empty, almost_full, full} ==
                {VECS[v].e, VECS[v].ae, VECS[v].af, VECS[v].f}, "R5/R6 flags",
                int'({empty, almost_empty, almost_full, full}),
                int'({VECS[v].e, VECS[v].ae, VECS[v].af, VECS[v].f}));
            drain(VECS[v].k, 16 + v * 16);
            repeat (10) @(negedge clk);
            chk(empty == 1'b1, "R9 empty after drain", int'(empty), 1);
        end

        // R2 latency: write on edge e0, empty clears after e(N-1)
        do_reset();
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hA5;
        @(negedge clk); wr_en = 1'b0;
        for (int e = 1; e < N; e++) begin
            chk(empty == 1'b1, "R2 still empty", int'(empty), 1);
            @(negedge clk);
        end
        chk(empty == 1'b0, "R2 arrival", int'(empty), 0);
        chk(rd_data == '0, "R7 no read yet", int'(rd_data), 0);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(rd_data == 8'hA5, "R7 read data", int'(rd_data), 8'hA5);

        // R4 read while empty ignored
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == 8'hA5, "R4 data held", int'(rd_data), 8'hA5);
        chk(empty == 1'b1, "R4 still empty", int'(empty), 1);
        write_run(1, 8'h3C);
        repeat (10) @(negedge clk);
        drain(1, 8'h3C);

        // R3 capacity and writes while full
        do_reset();
        write_run(CAP, 8'h40);
        repeat (10) @(negedge clk);
        chk(full == 1'b1, "R3 full at capacity", int'(full), 1);
        wr_data = 8'hEE; wr_en = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        chk(full == 1'b1, "R3 full held", int'(full), 1);
        drain(CAP, 8'h40);
        repeat (10) @(negedge clk);
        chk(empty == 1'b1, "R3 nothing extra stored", int'(empty), 1);

        // R9 random bursts with reference queue
        do_reset();
        begin
            int head = 0, tail = 0;
            bit pend = 1'b0;
            logic [15:0] lfsr = 16'hACE1;
            for (int c = 0; c < 4000; c++) begin
                @(negedge clk);
                if (pend) begin
                    chk(rd_data == refq[head % 4096], "R9 random order",
                        int'(rd_data), int'(refq[head % 4096]));
                    head++; pend = 1'b0;
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if ((c / 100) % 2 == 0) begin
                    wr_en = lfsr[0] | lfsr[1]; rd_en = lfsr[2] & lfsr[3];
                end else begin
                    wr_en = lfsr[0] & lfsr[1]; rd_en = lfsr[2] | lfsr[3];
                end
                wr_data = lfsr[11:4];
                if (wr_en && !full) begin
                    refq[tail % 4096] = wr_data; tail++;
                end
                if (rd_en && !empty) pend = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            if (pend) begin
                chk(rd_data == refq[head % 4096], "R9 random order",
                    int'(rd_data), int'(refq[head % 4096]));
                head++;
            end
            repeat (40) @(negedge clk);
            while (head < tail) begin
                @(negedge clk);
                if (!empty) begin
                    rd_en = 1'b1;
                    @(negedge clk); rd_en = 1'b0;
                    chk(rd_data == refq[head % 4096], "R9 tail order",
                        int'(rd_data), int'(refq[head % 4096]));
                    head++;
                end
            end
            chk(head == tail, "R9 all words out", head, tail);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule